// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block is a first-in first-out buffer, 64 words deep and 36 bits wide, whose write side and read side each run on their own clock. The two clocks may be fully unrelated. Words enter on the write clock and leave through a registered output on the read clock. Each side keeps its own pointer. The pointers cross to the other side in Gray code through a chain of flip-flops.

Four active-low status flags report the fill level. Empty and almost-empty belong to the read side. Full and almost-full belong to the write side. A flag asserts as soon as its own side's operation reaches the threshold. It deasserts only after an operation on the far side has crossed the two-stage synchronizer, which takes two rising edges of the flag's own clock. The almost threshold X is a single value taken from four presets while reset is held. It sets both almost-empty and almost-full, one near each end of the buffer.

A typical producer writes while `full_n` is high. A typical consumer reads while `empty_n` is high. Either side can use the almost flags to start or stop a burst early.

Top module: `dual_clock_flag_fifo`

## Requirements
- R1: While `rst_n` is low, and until the first operation after it rises, `empty_n`=0, `almost_empty_n`=0, `full_n`=1 and `almost_full_n`=1.
- R2: Words leave in the order they were accepted, with all 36 bits intact. `rd_data` takes the next word on the read-clock edge at which `rd_en`=1 and `empty_n`=1.
- R3: `empty_n` is low exactly when the read side sees 0 words. After a write into an empty buffer, `empty_n` is still low after the first rising read-clock edge following that write, and high after the second. A read on the third edge is accepted.
- R4: `full_n` goes low right after the write edge that stores the 64th word. A write attempted while `full_n` is low is not stored.
- R5: After a read from a full buffer, `full_n` is still low after the first rising write-clock edge and high after the second. A write on the next edge is accepted.
- R6: `almost_empty_n` is low while X or fewer words are seen. After the write that brings the count to X+1, it is still low after the first rising read-clock edge and high after the second.
- R7: `almost_full_n` is high at 64−X−1 words. It is low right after the write edge that brings the count to 64−X.
- R8: A read attempted while `empty_n` is low is ignored: `rd_data` holds its value and the read position does not move.
- R9: `offset_sel` is sampled while `rst_n` is low and sets X as follows: 0 gives 4, 1 gives 8, 2 gives 12, 3 gives 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low reset for both sides |
| offset_sel | input | 2 | Preset select for the almost threshold, sampled during reset |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Word to write |
| full_n | output | 1 | Low when 64 words are stored (write clock) |
| almost_full_n | output | 1 | Low when 64−X or more words are stored (write clock) |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when no word is stored (read clock) |
| almost_empty_n | output | 1 | Low when X or fewer words are stored (read clock) |

## Verification
A flag set by its own side's operation is due right after that edge. The bench samples it two nanoseconds later. A flag released by the far side is due on the second rising edge of its own clock after the far-side edge. The bench counts edges of each clock and stores the count at the moment of the far-side operation. It then checks that the flag has not moved after one edge and has moved after two. A read word is due on the read edge that accepts it. The scoreboard records each accepted read at the falling edge before that rising edge and compares `rd_data` at the next falling edge.

// File: rtl/afifo_pkg.sv
`timescale 1ns/100ps
package afifo_pkg;

   typedef logic [1:0] offset_sel_t;

   // Almost threshold for a preset select: step, 2*step, 3*step, 4*step
   function automatic int unsigned almost_offset(input offset_sel_t sel,
                                                 input int unsigned step);
      return step * (int'(sel) + 1);
   endfunction

endpackage

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/100ps
module fifo_ptr_sync #(
   parameter int PW     = 7,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);

   logic [PW-1:0] stage_q [STAGES];
   logic          acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= gray_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   // Gray to binary on the last stage
   always_comb begin
      acc = 1'b0;
      for (int i = PW - 1; i >= 0; i--) begin
         acc        = acc ^ stage_q[STAGES-1][i];
         bin_out[i] = acc;
      end
   end

endmodule

// File: rtl/fifo_store.sv
`timescale 1ns/100ps
module fifo_store #(
   parameter int DATA_W    = 36,
   parameter int ADDR_W    = 6,
   parameter bit OUT_RESET = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              rst_n,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (OUT_RESET) begin : g_out_rst
         always_ff @(posedge rd_clk or negedge rst_n) begin
            if (!rst_n)  rdata <= '0;
            else if (re) rdata <= mem[raddr];
         end
      end else begin : g_out_plain
         always_ff @(posedge rd_clk) begin
            if (re) rdata <= mem[raddr];
         end
      end
   endgenerate

endmodule

// File: rtl/fifo_wr_ctrl.sv
`timescale 1ns/100ps
module fifo_wr_ctrl
   import afifo_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int OFFSET_STEP = 4,
   localparam int PW         = ADDR_W + 1,
   localparam int DEPTH      = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  offset_sel_t       offset_sel,
   input  logic              wr_en,
   input  logic [PW-1:0]     rgray_async,
   output logic [PW-1:0]     wgray,
   output logic [ADDR_W-1:0] waddr,
   output logic              accept,
   output logic              full_n,
   output logic              almost_full_n
);

   logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, rptr_seen, occ, x_q;

   fifo_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rsync (
      .clk     (clk),
      .rst_n   (rst_n),
      .gray_in (rgray_async),
      .bin_out (rptr_seen)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) x_q <= PW'(almost_offset(offset_sel, OFFSET_STEP));
   end

   assign occ           = wptr_q - rptr_seen;
   assign full_n        = (occ != PW'(DEPTH));
   assign almost_full_n = !rst_n || (occ < (PW'(DEPTH) - x_q));
   assign accept        = wr_en && full_n;
   assign wptr_nxt      = wptr_q + PW'(1);
   assign waddr         = wptr_q[ADDR_W-1:0];
   assign wgray         = wgray_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q  <= '0;
         wgray_q <= '0;
      end else if (accept) begin
         wptr_q  <= wptr_nxt;
         wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      end
   end

   assert_write_blocked_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |=> $stable(wptr_q));
   assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH));
   assert_full_implies_afull_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n |-> !almost_full_n);
   assert_wgray_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wgray_q ^ $past(wgray_q)) <= 1);

endmodule

// File: rtl/fifo_rd_ctrl.sv
`timescale 1ns/100ps
module fifo_rd_ctrl
   import afifo_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int OFFSET_STEP = 4,
   localparam int PW         = ADDR_W + 1,
   localparam int DEPTH      = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  offset_sel_t       offset_sel,
   input  logic              rd_en,
   input  logic [PW-1:0]     wgray_async,
   output logic [PW-1:0]     rgray,
   output logic [ADDR_W-1:0] raddr,
   output logic              fire,
   output logic              empty_n,
   output logic              almost_empty_n
);

   logic [PW-1:0] rptr_q, rptr_nxt, rgray_q, wptr_seen, occ, x_q;

   fifo_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wsync (
      .clk     (clk),
      .rst_n   (rst_n),
      .gray_in (wgray_async),
      .bin_out (wptr_seen)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) x_q <= PW'(almost_offset(offset_sel, OFFSET_STEP));
   end

   assign occ            = wptr_seen - rptr_q;
   assign empty_n        = (occ != '0);
   assign almost_empty_n = rst_n && (occ > x_q);
   assign fire           = rd_en && empty_n;
   assign rptr_nxt       = rptr_q + PW'(1);
   assign raddr          = rptr_q[ADDR_W-1:0];
   assign rgray          = rgray_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr_q  <= '0;
         rgray_q <= '0;
      end else if (fire) begin
         rptr_q  <= rptr_nxt;
         rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      end
   end

   assert_read_blocked_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |=> $stable(rptr_q));
   assert_empty_implies_aempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !empty_n |-> !almost_empty_n);
   assert_occ_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= PW'(DEPTH));
   assert_rgray_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray_q ^ $past(rgray_q)) <= 1);

endmodule

// File: rtl/dual_clock_flag_fifo.sv
`timescale 1ns/100ps
module dual_clock_flag_fifo
   import afifo_pkg::*;
#(
   parameter int DATA_W      = 36,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2,
   parameter int OFFSET_STEP = 4,
   parameter bit OUT_RESET   = 1'b1
) (
   input  logic              rst_n,
   input  logic [1:0]        offset_sel,
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full_n,
   output logic              almost_full_n,
   input  logic              rd_clk,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty_n,
   output logic              almost_empty_n
);

   localparam int PW    = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
      if (4 * OFFSET_STEP >= DEPTH / 2) begin : g_bad_offset
         $error("largest almost offset must stay below half the depth");
      end
   endgenerate

   logic [PW-1:0]     wgray, rgray;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              wr_accept, rd_fire;

   fifo_wr_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .OFFSET_STEP(OFFSET_STEP)) u_wr (
      .clk           (wr_clk),
      .rst_n         (rst_n),
      .offset_sel    (offset_sel),
      .wr_en         (wr_en),
      .rgray_async   (rgray),
      .wgray         (wgray),
      .waddr         (waddr),
      .accept        (wr_accept),
      .full_n        (full_n),
      .almost_full_n (almost_full_n)
   );

   fifo_rd_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .OFFSET_STEP(OFFSET_STEP)) u_rd (
      .clk            (rd_clk),
      .rst_n          (rst_n),
      .offset_sel     (offset_sel),
      .rd_en          (rd_en),
      .wgray_async    (wgray),
      .rgray          (rgray),
      .raddr          (raddr),
      .fire           (rd_fire),
      .empty_n        (empty_n),
      .almost_empty_n (almost_empty_n)
   );

   fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUT_RESET(OUT_RESET)) u_store (
      .wr_clk (wr_clk),
      .we     (wr_accept),
      .waddr  (waddr),
      .wdata  (wr_data),
      .rd_clk (rd_clk),
      .rst_n  (rst_n),
      .re     (rd_fire),
      .raddr  (raddr),
      .rdata  (rd_data)
   );

   assert_out_stable_when_empty_R8: assert property (@(posedge rd_clk) disable iff (!rst_n)
      !empty_n |=> $stable(rd_data));

endmodule

// File: tb/test_dual_clock_flag_fifo.sv
`timescale 1ns/100ps
module test_dual_clock_flag_fifo;

   localparam int DW    = 36;
   localparam int DEPTH = 64;

   logic          rst_n = 1'b0;
   logic [1:0]    offset_sel = 2'd1;
   logic          wr_clk = 1'b0, rd_clk = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          full_n, almost_full_n, empty_n, almost_empty_n;

   dual_clock_flag_fifo i_dual_clock_flag_fifo (
      .rst_n(rst_n), .offset_sel(offset_sel),
      .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data),
      .full_n(full_n), .almost_full_n(almost_full_n),
      .rd_clk(rd_clk), .rd_en(rd_en), .rd_data(rd_data),
      .empty_n(empty_n), .almost_empty_n(almost_empty_n)
   );

   // 50 MHz write clock; read clock 27 ns, rising edges never on a whole ns
   always #10 wr_clk = ~wr_clk;
   initial begin
      #3.5;
      forever begin rd_clk = ~rd_clk; #13.5; end
   end

   int checks = 0, failures = 0;
   int wr_edges = 0, rd_edges = 0;
   logic [DW-1:0] exp_q [$];
   bit pend = 1'b0;
   int word_no = 0;

   always @(posedge wr_clk) wr_edges++;
   always @(posedge rd_clk) rd_edges++;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // Scoreboard monitor: a read is known at the falling edge before it happens
   always @(negedge rd_clk) begin
      if (pend) begin
         if (exp_q.size() == 0) chk("R2 unexpected word", 64'(rd_data), 64'hDEAD);
         else chk("R2 order/data", 64'(rd_data), 64'(exp_q.pop_front()));
      end
      pend = rst_n && rd_en && empty_n;
   end

   function automatic logic [DW-1:0] pattern(input int k);
      logic [31:0] h = 32'(k) * 32'h9E3779B1;
      return {4'(k), h};
   endfunction

   task automatic wr_word(output bit acc, output int snap);
      @(posedge wr_clk); #2;
      wr_en = 1'b1; wr_data = pattern(word_no); acc = full_n;
      @(posedge wr_clk);
      snap = rd_edges;
      if (acc) exp_q.push_back(pattern(word_no));
      word_no++;
      #2 wr_en = 1'b0;
   endtask

   task automatic wr_n(input int n);
      bit a; int s;
      for (int i = 0; i < n; i++) wr_word(a, s);
   endtask

   task automatic rd_word(output int snap);
      @(posedge rd_clk); #2 rd_en = 1'b1;
      @(posedge rd_clk); snap = wr_edges;
      #2 rd_en = 1'b0;
   endtask

   task automatic rd_burst(input int n);
      @(posedge rd_clk); #2 rd_en = 1'b1;
      repeat (n) @(posedge rd_clk);
      #2 rd_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(posedge rd_clk);
      repeat (4) @(posedge wr_clk);
      #2;
   endtask

   task automatic do_reset(input logic [1:0] sel);
      rst_n = 1'b0; offset_sel = sel; wr_en = 1'b0; rd_en = 1'b0;
      repeat (4) @(posedge wr_clk);
      repeat (4) @(posedge rd_clk);
      #1;
      chk("R1 empty_n in reset", 64'(empty_n), 64'd0);
      chk("R1 full_n in reset", 64'(full_n), 64'd1);
      exp_q.delete();
      #1 rst_n = 1'b1;
      settle();
      chk("R1 empty_n", 64'(empty_n), 64'd0);
      chk("R1 almost_empty_n", 64'(almost_empty_n), 64'd0);
      chk("R1 full_n", 64'(full_n), 64'd1);
      chk("R1 almost_full_n", 64'(almost_full_n), 64'd1);
   endtask

   initial begin
      #4000000;
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      bit acc; int snap; logic [DW-1:0] last;

      // X = 8
      do_reset(2'd1);

      // R3: empty to one word
      wr_word(acc, snap);
      wait (rd_edges >= snap + 1); #1;
      chk("R3 empty_n after 1st rd edge", 64'(empty_n), 64'd0);
      wait (rd_edges >= snap + 2); #1;
      chk("R3 empty_n after 2nd rd edge", 64'(empty_n), 64'd1);
      chk("R6 almost_empty_n at 1 word", 64'(almost_empty_n), 64'd0);
      rd_word(snap);
      chk("R3 empty_n after last read", 64'(empty_n), 64'd0);
      @(negedge rd_clk); #1;
      last = rd_data;

      // R8: reads while empty are ignored
      rd_burst(3);
      #1;
      chk("R8 rd_data held", 64'(rd_data), 64'(last));
      chk("R8 still empty", 64'(empty_n), 64'd0);

      // R6: X to X+1 words
      wr_n(8);
      settle();
      chk("R6 almost_empty_n at X", 64'(almost_empty_n), 64'd0);
      wr_word(acc, snap);
      wait (rd_edges >= snap + 1); #1;
      chk("R6 almost_empty_n after 1st rd edge", 64'(almost_empty_n), 64'd0);
      wait (rd_edges >= snap + 2); #1;
      chk("R6 almost_empty_n after 2nd rd edge", 64'(almost_empty_n), 64'd1);

      // R7: 64-X-1 to 64-X words
      wr_n(55 - 9);
      settle();
      chk("R7 almost_full_n at 55", 64'(almost_full_n), 64'd1);
      wr_word(acc, snap);
      chk("R7 almost_full_n at 56", 64'(almost_full_n), 64'd0);
      chk("R4 full_n at 56", 64'(full_n), 64'd1);

      // R4: fill and try one more
      wr_n(8);
      chk("R4 full_n at 64", 64'(full_n), 64'd0);
      wr_word(acc, snap);
      chk("R4 write while full refused", 64'(acc), 64'd0);
      settle();

      // R5: full to 63 words
      rd_word(snap);
      wait (wr_edges >= snap + 1); #1;
      chk("R5 full_n after 1st wr edge", 64'(full_n), 64'd0);
      wait (wr_edges >= snap + 2); #1;
      chk("R5 full_n after 2nd wr edge", 64'(full_n), 64'd1);
      chk("R7 almost_full_n at 63", 64'(almost_full_n), 64'd0);
      wr_word(acc, snap);
      chk("R5 write accepted after release", 64'(acc), 64'd1);
      settle();

      // R2/R4: drain all 64 through the scoreboard
      rd_burst(DEPTH);
      settle();
      chk("R4 empty after 64 reads", 64'(empty_n), 64'd0);
      chk("R2 scoreboard drained", 64'(exp_q.size()), 64'd0);

      // R9: X = 16
      do_reset(2'd3);
      wr_n(16);
      settle();
      chk("R9 almost_empty_n at 16", 64'(almost_empty_n), 64'd0);
      wr_n(1);
      settle();
      chk("R9 almost_empty_n at 17", 64'(almost_empty_n), 64'd1);
      wr_n(47 - 17);
      settle();
      chk("R9 almost_full_n at 47", 64'(almost_full_n), 64'd1);
      wr_n(1);
      chk("R9 almost_full_n at 48", 64'(almost_full_n), 64'd0);
      rd_burst(48);
      settle();
      chk("R2 scoreboard drained X=16", 64'(exp_q.size()), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule